// File: doc/BRIEF.md
# Exception Entry Sequencer

This block carries out the entry into an exception handler for a processor core. When a request arrives with a 3-bit cause code, the block looks up the cause in its table. The table gives four things: the privileged mode to enter, the handler vector, the interrupt-disable bits to force on, and the amount to add to the current program counter to form the return address. The vector base can be moved to the top of the address space with a single control input.

An entry runs through a small state machine with three states. In ST_IDLE the block waits for a request. On an accepted request (transition IDLE->SWITCH) it captures the cause, the status word, the PC and the instruction-set state. In ST_SWITCH it holds a request to the register-bank switcher, naming the target mode, until the switcher reports completion. That completion is transition SWITCH->COMMIT: the new status word, the saved status, the link value and the new PC are all registered on that edge. In ST_COMMIT the block pulses a one-cycle completion strobe and then returns to idle (transition COMMIT->IDLE). Requests that arrive outside ST_IDLE are ignored, and so is the reserved cause code.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset, bank_req and entry_done are low, and new_status, saved_status, link_addr and new_pc are all zero.
- R2: A request with exc_valid high and exc_code 0..6, sampled in idle, raises bank_req in the next cycle. bank_mode then carries the target mode, and bank_req stays high until bank_done is sampled high.
- R3: entry_done is high for exactly one cycle: the cycle after the edge where bank_done was sampled high while bank_req was high. The four result outputs hold their new values from that cycle onward.
- R4: The target mode (status bits 4:0) and the vector offset for each cause are as follows. Code 0 (undefined instruction) enters mode 0x1B at 0x04. Code 1 (software trap) enters 0x13 at 0x08. Code 2 (prefetch abort) and code 3 (breakpoint) enter 0x17 at 0x0C. Code 4 (data abort) enters 0x17 at 0x10. Code 5 (normal interrupt) enters 0x12 at 0x18. Code 6 (fast interrupt) enters 0x11 at 0x1C.
- R5: The return offset is 4 for codes 0, 2, 3, 5 and 6. The exception is code 0 when narrow_isa is high, which uses 2. Code 1 uses 0 and code 4 uses 8.
- R6: With high_vec high, the value 0xFFFF0000 is added to the vector offset to form new_pc.
- R7: saved_status equals cur_status as it was sampled with the accepted request.
- R8: new_status is the captured status with several changes. Bits 4:0 are replaced by the target mode and bit 5 (instruction-set state) is cleared. Bit 7 (I) is ORed in for every cause. Bit 8 (A) is ORed in for codes 2 to 6, and bit 6 (F) only for code 6. All other bits are unchanged, and mask bits that were already set stay set.
- R9: link_addr equals the captured PC plus the return offset, modulo 2^32, and new_pc equals the vector.
- R10: Code 7 is ignored. bank_req stays low, entry_done stays low, and all result outputs keep their values.
- R11: Changes to exc_valid, exc_code, cur_status, cur_pc, narrow_isa or high_vec while an entry is in progress do not affect that entry's results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_valid | input | 1 | Exception request strobe |
| exc_code | input | 3 | Cause code (0..6 legal, 7 reserved) |
| cur_status | input | 32 | Status word before entry |
| cur_pc | input | 32 | Program counter before entry |
| narrow_isa | input | 1 | Core is executing the compact instruction set |
| high_vec | input | 1 | Relocate vectors to the top of the address space |
| bank_done | input | 1 | Bank switcher has finished |
| bank_req | output | 1 | Request to the bank switcher |
| bank_mode | output | 5 | Mode to switch banks to |
| new_status | output | 32 | Status word after entry |
| saved_status | output | 32 | Saved copy of the old status |
| link_addr | output | 32 | Return address for the link register |
| new_pc | output | 32 | Handler address |
| entry_done | output | 1 | One-cycle completion strobe |

## Verification
bank_req and bank_mode are due one cycle after the request edge. The four results and entry_done are due one cycle after the edge that samples bank_done, and entry_done must be low again one cycle later. The bench drives every input on the falling edge and samples on the next falling edge, so each check falls exactly half a cycle after the rising edge that should produce the value. The sweep covers all eight cause codes, both instruction-set states, both vector bases, three status patterns and bank-switch delays of zero to two cycles. An extra run changes every input during the switch wait.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    typedef enum logic [2:0] {
        EXC_UNDEF = 3'd0,
        EXC_TRAP  = 3'd1,
        EXC_PFABT = 3'd2,
        EXC_BRKPT = 3'd3,
        EXC_DABT  = 3'd4,
        EXC_NIRQ  = 3'd5,
        EXC_FIRQ  = 3'd6,
        EXC_RSVD  = 3'd7
    } exc_code_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SWITCH = 2'd1,
        ST_COMMIT = 2'd2
    } seq_state_e;

    localparam int MODE_W = 5;
    localparam int BIT_T  = 5;
    localparam int BIT_F  = 6;
    localparam int BIT_I  = 7;
    localparam int BIT_A  = 8;

    localparam logic [MODE_W-1:0] MODE_FAST = 5'h11;
    localparam logic [MODE_W-1:0] MODE_NORM = 5'h12;
    localparam logic [MODE_W-1:0] MODE_SUPV = 5'h13;
    localparam logic [MODE_W-1:0] MODE_ABRT = 5'h17;
    localparam logic [MODE_W-1:0] MODE_UNDF = 5'h1B;

    typedef struct packed {
        logic              legal;
        logic [MODE_W-1:0] mode;
        logic [7:0]        vec_off;
        logic              set_a;
        logic              set_i;
        logic              set_f;
        logic [3:0]        ret_off;
    } exc_attr_t;

endpackage

// File: rtl/exc_vector_table.sv
module exc_vector_table
    import exc_entry_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter logic [31:0] HIGH_BASE = 32'hFFFF_0000
) (
    input  logic [2:0]        code,
    input  logic              narrow,
    input  logic              high_vec,
    output exc_attr_t         attr,
    output logic [ADDR_W-1:0] vector
);

    localparam logic [ADDR_W-1:0] BASE_HI = HIGH_BASE[ADDR_W-1:0];

    always_comb begin
        attr = '0;
        unique case (exc_code_e'(code))
            EXC_UNDEF: begin
                attr.legal   = 1'b1;
                attr.mode    = MODE_UNDF;
                attr.vec_off = 8'h04;
                attr.set_i   = 1'b1;
                attr.ret_off = narrow ? 4'd2 : 4'd4;
            end
            EXC_TRAP: begin
                attr.legal   = 1'b1;
                attr.mode    = MODE_SUPV;
                attr.vec_off = 8'h08;
                attr.set_i   = 1'b1;
                attr.ret_off = 4'd0;
            end
            EXC_PFABT, EXC_BRKPT: begin
                attr.legal   = 1'b1;
                attr.mode    = MODE_ABRT;
                attr.vec_off = 8'h0C;
                attr.set_a   = 1'b1;
                attr.set_i   = 1'b1;
                attr.ret_off = 4'd4;
            end
            EXC_DABT: begin
                attr.legal   = 1'b1;
                attr.mode    = MODE_ABRT;
                attr.vec_off = 8'h10;
                attr.set_a   = 1'b1;
                attr.set_i   = 1'b1;
                attr.ret_off = 4'd8;
            end
            EXC_NIRQ: begin
                attr.legal   = 1'b1;
                attr.mode    = MODE_NORM;
                attr.vec_off = 8'h18;
                attr.set_a   = 1'b1;
                attr.set_i   = 1'b1;
                attr.ret_off = 4'd4;
            end
            EXC_FIRQ: begin
                attr.legal   = 1'b1;
                attr.mode    = MODE_FAST;
                attr.vec_off = 8'h1C;
                attr.set_a   = 1'b1;
                attr.set_i   = 1'b1;
                attr.set_f   = 1'b1;
                attr.ret_off = 4'd4;
            end
            EXC_RSVD: begin
                attr = '0;
            end
        endcase
    end

    always_comb begin
        vector = {{(ADDR_W-8){1'b0}}, attr.vec_off};
        if (high_vec) begin
            vector = vector + BASE_HI;
        end
    end

endmodule

// File: rtl/exc_status_update.sv
module exc_status_update
    import exc_entry_pkg::*;
#(
    parameter int STAT_W = 32
) (
    input  logic [STAT_W-1:0] old_status,
    input  logic [MODE_W-1:0] mode,
    input  logic              set_a,
    input  logic              set_i,
    input  logic              set_f,
    output logic [STAT_W-1:0] new_status
);

    logic [STAT_W-1:0] or_mask;

    always_comb begin
        or_mask        = '0;
        or_mask[BIT_A] = set_a;
        or_mask[BIT_I] = set_i;
        or_mask[BIT_F] = set_f;
    end

    for (genvar b = 0; b < STAT_W; b++) begin : g_bit
        if (b < MODE_W) begin : g_mode
            assign new_status[b] = mode[b];
        end else if (b == BIT_T) begin : g_tflag
            assign new_status[b] = 1'b0;
        end else begin : g_keep
            assign new_status[b] = old_status[b] | or_mask[b];
        end
    end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter int          STAT_W    = 32,
    parameter logic [31:0] HIGH_BASE = 32'hFFFF_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_valid,
    input  logic [2:0]        exc_code,
    input  logic [STAT_W-1:0] cur_status,
    input  logic [ADDR_W-1:0] cur_pc,
    input  logic              narrow_isa,
    input  logic              high_vec,
    input  logic              bank_done,
    output logic              bank_req,
    output logic [4:0]        bank_mode,
    output logic [STAT_W-1:0] new_status,
    output logic [STAT_W-1:0] saved_status,
    output logic [ADDR_W-1:0] link_addr,
    output logic [ADDR_W-1:0] new_pc,
    output logic              entry_done
);

    seq_state_e state_q, state_d;

    exc_attr_t         dec_attr;
    logic [ADDR_W-1:0] dec_vector;
    logic              accept;
    logic              commit;

    exc_attr_t         cap_attr;
    logic [ADDR_W-1:0] cap_vector;
    logic [STAT_W-1:0] cap_status;
    logic [ADDR_W-1:0] cap_pc;
    logic [STAT_W-1:0] upd_status;

    exc_vector_table #(
        .ADDR_W    (ADDR_W),
        .HIGH_BASE (HIGH_BASE)
    ) u_table (
        .code     (exc_code),
        .narrow   (narrow_isa),
        .high_vec (high_vec),
        .attr     (dec_attr),
        .vector   (dec_vector)
    );

    exc_status_update #(
        .STAT_W (STAT_W)
    ) u_update (
        .old_status (cap_status),
        .mode       (cap_attr.mode),
        .set_a      (cap_attr.set_a),
        .set_i      (cap_attr.set_i),
        .set_f      (cap_attr.set_f),
        .new_status (upd_status)
    );

    assign accept = (state_q == ST_IDLE) && exc_valid && dec_attr.legal;
    assign commit = (state_q == ST_SWITCH) && bank_done;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = ST_SWITCH;
            ST_SWITCH: if (bank_done) state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_attr     <= '0;
            cap_vector   <= '0;
            cap_status   <= '0;
            cap_pc       <= '0;
            new_status   <= '0;
            saved_status <= '0;
            link_addr    <= '0;
            new_pc       <= '0;
        end else begin
            if (accept) begin
                cap_attr   <= dec_attr;
                cap_vector <= dec_vector;
                cap_status <= cur_status;
                cap_pc     <= cur_pc;
            end
            if (commit) begin
                new_status   <= upd_status;
                saved_status <= cap_status;
                link_addr    <= cap_pc + {{(ADDR_W-4){1'b0}}, cap_attr.ret_off};
                new_pc       <= cap_vector;
            end
        end
    end

    always_comb begin
        bank_req   = (state_q == ST_SWITCH);
        entry_done = (state_q == ST_COMMIT);
        bank_mode  = cap_attr.mode;
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_req && !bank_done) |=> bank_req) else $error("req dropped"); // R2

    AST_REQ_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!bank_req && !entry_done && exc_valid && exc_code != 3'd7) |=> bank_req) else $error("no req"); // R2

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        entry_done |=> !entry_done) else $error("done too long"); // R3

    AST_DONE_AFTER_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(entry_done) |-> $past(bank_req && bank_done)) else $error("done w/o bank"); // R3

    AST_MODE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        entry_done |-> (new_status[MODE_W-1:0] == bank_mode)) else $error("mode"); // R8

    AST_TFLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        entry_done |-> !new_status[BIT_T]) else $error("tflag"); // R8

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        entry_done |-> new_status[BIT_I]) else $error("imask"); // R8

    AST_RESULTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bank_req && bank_done) |=> ($stable(saved_status) && $stable(new_pc) && $stable(link_addr))) else $error("results moved"); // R10

endmodule

// File: tb/exc_entry_seq_tb.sv
`timescale 1ns/1ps
module exc_entry_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_valid = 1'b0;
    logic [2:0]  exc_code = 3'd0;
    logic [31:0] cur_status = '0;
    logic [31:0] cur_pc = '0;
    logic        narrow_isa = 1'b0;
    logic        high_vec = 1'b0;
    logic        bank_done = 1'b0;
    logic        bank_req;
    logic [4:0]  bank_mode;
    logic [31:0] new_status;
    logic [31:0] saved_status;
    logic [31:0] link_addr;
    logic [31:0] new_pc;
    logic        entry_done;

    int checks = 0;
    int fails = 0;

    logic [31:0] last_ns = '0, last_ss = '0, last_la = '0, last_pc = '0;

    always #2.5 clk = ~clk;

    exc_entry_seq u_dut (
        .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_code(exc_code),
        .cur_status(cur_status), .cur_pc(cur_pc), .narrow_isa(narrow_isa),
        .high_vec(high_vec), .bank_done(bank_done), .bank_req(bank_req),
        .bank_mode(bank_mode), .new_status(new_status), .saved_status(saved_status),
        .link_addr(link_addr), .new_pc(new_pc), .entry_done(entry_done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [4:0] exp_mode(input int c);
        case (c)
            0: return 5'h1B;
            1: return 5'h13;
            2, 3, 4: return 5'h17;
            5: return 5'h12;
            default: return 5'h11;
        endcase
    endfunction

    function automatic logic [31:0] exp_vec(input int c, input logic hv);
        logic [31:0] v;
        case (c)
            0: v = 32'h04;
            1: v = 32'h08;
            2, 3: v = 32'h0C;
            4: v = 32'h10;
            5: v = 32'h18;
            default: v = 32'h1C;
        endcase
        return hv ? v + 32'hFFFF_0000 : v;
    endfunction

    function automatic logic [31:0] exp_off(input int c, input logic nar);
        case (c)
            0: return nar ? 32'd2 : 32'd4;
            1: return 32'd0;
            4: return 32'd8;
            default: return 32'd4;
        endcase
    endfunction

    function automatic logic [31:0] exp_stat(input int c, input logic [31:0] s);
        logic [31:0] r;
        r = s;
        r[7] = 1'b1;
        if (c >= 2) r[8] = 1'b1;
        if (c == 6) r[6] = 1'b1;
        r[5] = 1'b0;
        r[4:0] = exp_mode(c);
        return r;
    endfunction

    task automatic run_entry(input int c, input logic [31:0] st, input logic [31:0] pc,
                             input logic nar, input logic hv, input int dly, input bit disturb);
        @(negedge clk);
        exc_code = 3'(c); cur_status = st; cur_pc = pc; narrow_isa = nar; high_vec = hv;
        exc_valid = 1'b1;
        @(negedge clk);
        exc_valid = 1'b0;
        if (c == 7) begin
            bank_done = 1'b1;
            chk("R10 bank_req", {31'b0, bank_req}, 32'd0);
            @(negedge clk);
            bank_done = 1'b0;
            chk("R10 entry_done", {31'b0, entry_done}, 32'd0);
            chk("R10 new_status", new_status, last_ns);
            chk("R10 saved_status", saved_status, last_ss);
            chk("R10 link_addr", link_addr, last_la);
            chk("R10 new_pc", new_pc, last_pc);
            return;
        end
        chk("R2 bank_req", {31'b0, bank_req}, 32'd1);
        chk("R2 bank_mode", {27'b0, bank_mode}, {27'b0, exp_mode(c)});
        if (disturb) begin
            exc_valid = 1'b1; exc_code = 3'd6; cur_status = ~st; cur_pc = pc ^ 32'h5A5A_0000;
            narrow_isa = ~nar; high_vec = ~hv;
        end
        for (int k = 0; k < dly; k++) begin
            @(negedge clk);
            chk("R2 bank_req held", {31'b0, bank_req}, 32'd1);
            chk("R3 no early done", {31'b0, entry_done}, 32'd0);
        end
        bank_done = 1'b1;
        @(negedge clk);
        bank_done = 1'b0;
        exc_valid = 1'b0;
        last_ns = exp_stat(c, st);
        last_ss = st;
        last_la = pc + exp_off(c, nar);
        last_pc = exp_vec(c, hv);
        chk("R3 entry_done", {31'b0, entry_done}, 32'd1);
        chk(disturb ? "R11 status" : "R8 new_status", new_status, last_ns);
        chk(disturb ? "R11 saved" : "R7 saved_status", saved_status, last_ss);
        chk(disturb ? "R11 link" : "R5 R9 link_addr", link_addr, last_la);
        chk(disturb ? "R11 pc" : "R4 R6 R9 new_pc", new_pc, last_pc);
        @(negedge clk);
        chk("R3 done pulse", {31'b0, entry_done}, 32'd0);
        chk("R3 req low", {31'b0, bank_req}, 32'd0);
        chk("R3 hold pc", new_pc, last_pc);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 bank_req", {31'b0, bank_req}, 32'd0);
        chk("R1 entry_done", {31'b0, entry_done}, 32'd0);
        chk("R1 new_status", new_status, 32'd0);
        chk("R1 saved_status", saved_status, 32'd0);
        chk("R1 link_addr", link_addr, 32'd0);
        chk("R1 new_pc", new_pc, 32'd0);
        rst_n = 1'b1;
        for (int c = 0; c < 8; c++) begin
            for (int n = 0; n < 2; n++) begin
                for (int h = 0; h < 2; h++) begin
                    for (int p = 0; p < 3; p++) begin
                        logic [31:0] st;
                        st = (p == 0) ? 32'h0000_0000 : (p == 1) ? 32'hFFFF_FFFF : 32'h6000_0030;
                        run_entry(c, st, 32'h0000_1000 + 32'(c * 64 + n * 16 + h * 8 + p * 4),
                                  n[0], h[0], p, 1'b0);
                    end
                end
            end
        end
        run_entry(0, 32'h0000_0030, 32'hFFFF_FFFE, 1'b0, 1'b0, 1, 1'b0);
        run_entry(4, 32'h8000_0013, 32'h0000_2000, 1'b0, 1'b1, 2, 1'b1);
        run_entry(1, 32'h0000_0010, 32'h0000_3004, 1'b1, 1'b0, 0, 1'b1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule